// File: doc/BRIEF.md
# Mobile Handover Decision Controller

This block is the mobile-side controller that decides when a handover is worth asking for. Once per frame it compares the link quality of the best neighbour cell with that of the serving cell. The neighbour must beat the serving cell by more than a configured margin. That advantage must also hold for a configured number of consecutive frames. When both are true, the block raises a one-cycle request strobe, which tells the message layer to send a handover request.

After the request, the block waits for the base station's answer. It counts frames against a configured response limit while it waits. An accepting answer produces a one-cycle execute strobe. A rejecting answer, or no answer within the limit, drops the attempt and returns the block to normal operation. Any later request then needs a fresh, complete run of qualifying frames. Message encoding and network re-entry are handled elsewhere; this block only supplies the timers and the decision sequence.

Top module: `ho_decider`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `state_o` is 0 (normal) and `req_o` and `exec_o` are low.
- R2: A frame counts as advantaged only when `nbr_q_i > serv_q_i + margin_i`, compared without overflow. A neighbour that exceeds the serving quality by exactly the margin, or by less, does not count.
- R3: On the `dwell_len_i`-th consecutive advantaged frame tick, `req_o` is high in the cycle after that tick's clock edge and `state_o` becomes 2 (waiting). On the earlier advantaged ticks, `state_o` is 1 (pending) and `req_o` stays low.
- R4: A non-advantaged frame tick while in state 1 returns `state_o` to 0, and the count of consecutive frames restarts from zero.
- R5: The quality inputs are sampled only on cycles where `frame_tick_i` is high. On other cycles the state does not change, whatever values the quality inputs carry.
- R6: In state 2, `rsp_valid_i` with `rsp_accept_i`=1 makes `exec_o` high and `state_o` 3 (execute) in the next cycle. One cycle after that, `state_o` is 0. A response takes priority over a frame tick in the same cycle.
- R7: In state 2, `rsp_valid_i` with `rsp_accept_i`=0 returns `state_o` to 0 in the next cycle, and the count of consecutive frames is cleared.
- R8: In state 2 with no response, the `resp_tmo_i`-th frame tick returns `state_o` to 0. Cycles without a frame tick do not advance the timeout.
- R9: After a timeout or a rejection, no request is issued until a full new run of `dwell_len_i` consecutive advantaged ticks has been seen. Frame ticks that arrive while waiting do not count toward that run.
- R10: `req_o` and `exec_o` are never high for two cycles in a row. `rsp_valid_i` has no effect outside state 2.
- R11: A `dwell_len_i` of 0 acts as 1, and a `resp_tmo_i` of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_tick_i | input | 1 | One-cycle pulse per frame; qualifies the quality samples |
| serv_q_i | input | QW | Serving-cell link quality |
| nbr_q_i | input | QW | Best-neighbour link quality |
| margin_i | input | QW | Hysteresis margin the neighbour must exceed |
| dwell_len_i | input | DW | Number of consecutive advantaged frames required |
| resp_tmo_i | input | TW | Response limit, in frames |
| rsp_valid_i | input | 1 | A handover response has been received |
| rsp_accept_i | input | 1 | Response verdict, 1 = accept; valid with rsp_valid_i |
| req_o | output | 1 | One-cycle strobe: send a handover request |
| exec_o | output | 1 | One-cycle strobe: execute the handover |
| state_o | output | 2 | 0 normal, 1 pending, 2 waiting, 3 execute |

## Verification
Every result is registered exactly once. A strobe, a state change or a verdict therefore appears in the cycle immediately after the clock edge that samples the triggering tick or response, and not before. The bench drives each stimulus for one cycle starting at a falling edge. It then reads the outputs at the next falling edge, which is the first point where the result is due. It reads them again one cycle later to confirm that the strobes have dropped. The margin comparison is swept over a grid of serving, neighbour and margin values, with the expected verdict worked out arithmetically. Dwell lengths and timeout limits are swept over small ranges, including zero.

// File: rtl/ho_pkg.sv
package ho_pkg;
  typedef enum logic [1:0] {
    HO_NORMAL  = 2'd0,
    HO_PENDING = 2'd1,
    HO_WAIT    = 2'd2,
    HO_EXEC    = 2'd3
  } ho_state_e;
endpackage

// File: rtl/ho_adv_cmp.sv
module ho_adv_cmp #(
  parameter int QW = 6
) (
  input  logic [QW-1:0] serv_q_i,
  input  logic [QW-1:0] nbr_q_i,
  input  logic [QW-1:0] margin_i,
  output logic          adv_o
);
  logic [QW:0] bar;

  // one extra bit so serv + margin never wraps
  always_comb begin
    bar   = {1'b0, serv_q_i} + {1'b0, margin_i};
    adv_o = ({1'b0, nbr_q_i} > bar);
  end
endmodule

// File: rtl/ho_tick_cnt.sv
module ho_tick_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] limit_i,
  output logic         hit_o
);
  localparam logic [W-1:0] LIM_MIN = W'(1);
  localparam logic [W:0]   ONE     = (W+1)'(1);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q;
  logic [W-1:0] lim_eff;

  // a limit of 0 behaves as 1
  always_comb begin
    lim_eff = (limit_i == '0) ? LIM_MIN : limit_i;
    hit_o   = inc_i && (({1'b0, cnt_q} + ONE) >= {1'b0, lim_eff});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (clr_i)                       cnt_q <= '0;
    else if (inc_i && (cnt_q != CNT_MAX)) cnt_q <= cnt_q + W'(1);
  end

  // R9
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/ho_decider.sv
module ho_decider
  import ho_pkg::*;
#(
  parameter int QW = 6,
  parameter int DW = 8,
  parameter int TW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_tick_i,
  input  logic [QW-1:0] serv_q_i,
  input  logic [QW-1:0] nbr_q_i,
  input  logic [QW-1:0] margin_i,
  input  logic [DW-1:0] dwell_len_i,
  input  logic [TW-1:0] resp_tmo_i,
  input  logic          rsp_valid_i,
  input  logic          rsp_accept_i,
  output logic          req_o,
  output logic          exec_o,
  output logic [1:0]    state_o
);
  ho_state_e state_q, state_d;
  logic      req_d, exec_d;
  logic      adv;
  logic      scanning;
  logic      dwell_clr, dwell_inc, dwell_hit;
  logic      tmo_clr, tmo_inc, tmo_hit;

  ho_adv_cmp #(.QW(QW)) u_cmp (
    .serv_q_i (serv_q_i),
    .nbr_q_i  (nbr_q_i),
    .margin_i (margin_i),
    .adv_o    (adv)
  );

  always_comb begin
    scanning  = (state_q == HO_NORMAL) || (state_q == HO_PENDING);
    dwell_inc = scanning && frame_tick_i && adv;
    dwell_clr = !scanning || (frame_tick_i && !adv);
    tmo_clr   = (state_q != HO_WAIT);
    tmo_inc   = (state_q == HO_WAIT) && frame_tick_i && !rsp_valid_i;
  end

  ho_tick_cnt #(.W(DW)) u_dwell (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (dwell_clr),
    .inc_i   (dwell_inc),
    .limit_i (dwell_len_i),
    .hit_o   (dwell_hit)
  );

  ho_tick_cnt #(.W(TW)) u_tmo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (tmo_clr),
    .inc_i   (tmo_inc),
    .limit_i (resp_tmo_i),
    .hit_o   (tmo_hit)
  );

  always_comb begin
    state_d = state_q;
    req_d   = 1'b0;
    exec_d  = 1'b0;
    unique case (state_q)
      HO_NORMAL, HO_PENDING: begin
        if (frame_tick_i) begin
          if (!adv)           state_d = HO_NORMAL;
          else if (dwell_hit) begin
            state_d = HO_WAIT;
            req_d   = 1'b1;
          end else            state_d = HO_PENDING;
        end
      end
      HO_WAIT: begin
        // response outranks a coincident tick
        if (rsp_valid_i) begin
          if (rsp_accept_i) begin
            state_d = HO_EXEC;
            exec_d  = 1'b1;
          end else state_d = HO_NORMAL;
        end else if (tmo_hit) state_d = HO_NORMAL;
      end
      HO_EXEC: state_d = HO_NORMAL;
      default: state_d = HO_NORMAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HO_NORMAL;
      req_o   <= 1'b0;
      exec_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      req_o   <= req_d;
      exec_o  <= exec_d;
    end
  end

  assign state_o = state_q;

  // R10
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);
  // R10
  exec_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |=> !exec_o);
  // R3
  req_in_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (state_q == HO_WAIT) && $past(frame_tick_i));
  // R6
  exec_leave_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |=> (state_q == HO_NORMAL));
  // R5
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == HO_PENDING && !frame_tick_i) |=> (state_q == HO_PENDING));
  // R8
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == HO_WAIT && !frame_tick_i && !rsp_valid_i) |=> (state_q == HO_WAIT));
  // R7
  reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == HO_WAIT && rsp_valid_i && !rsp_accept_i) |=> (state_q == HO_NORMAL));
endmodule

// File: tb/ho_decider_bench.sv
module ho_decider_bench;
  localparam int QW = 6;
  localparam int DW = 8;
  localparam int TW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [QW-1:0] serv = '0, nbr = '0, margin = '0;
  logic [DW-1:0] dwell = '0;
  logic [TW-1:0] tmo = '0;
  logic          rv = 1'b0, ra = 1'b0;
  logic          req, exec_s;
  logic [1:0]    st;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  ho_decider u_ho_decider (
    .clk_i(clk), .rst_ni(rst_n), .frame_tick_i(tick),
    .serv_q_i(serv), .nbr_q_i(nbr), .margin_i(margin),
    .dwell_len_i(dwell), .resp_tmo_i(tmo),
    .rsp_valid_i(rv), .rsp_accept_i(ra),
    .req_o(req), .exec_o(exec_s), .state_o(st)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic ftick(int s, int n);
    serv = QW'(s); nbr = QW'(n); tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic rsp(bit acc);
    rv = 1'b1; ra = acc;
    @(negedge clk);
    rv = 1'b0; ra = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // advantaged tick helper: neighbour well above serving
  task automatic adv_tick();
    ftick(5, 40);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    margin = QW'(3); dwell = DW'(1); tmo = TW'(5);
    repeat (3) @(negedge clk);
    chk("R1 state in reset", int'(st), 0);
    chk("R1 req in reset", int'(req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 state after reset", int'(st), 0);
    chk("R1 exec after reset", int'(exec_s), 0);

    // R2 sweep with dwell 1: request iff nbr > serv + margin
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 8; s++) begin
        for (int n = 0; n < 16; n++) begin
          margin = QW'(m);
          ftick(s, n);
          chk("R2 verdict", int'(req), (n > s + m) ? 1 : 0);
          if (n > s + m) begin
            rsp(1'b0);
            chk("R7 reject to normal", int'(st), 0);
          end else begin
            chk("R2 no advance", int'(st), 0);
          end
        end
      end
    end
    // R2 overflow corner: serv + margin beyond range
    margin = QW'(63);
    ftick(63, 63);
    chk("R2 no wrap", int'(req), 0);
    margin = QW'(3);

    // R3 / R6 / R10 / R11 over dwell lengths 0..4
    for (int d = 0; d <= 4; d++) begin
      int eff;
      eff = (d == 0) ? 1 : d;
      dwell = DW'(d);
      for (int k = 1; k < eff; k++) begin
        adv_tick();
        chk("R3 early req", int'(req), 0);
        chk("R3 pending", int'(st), 1);
      end
      adv_tick();
      chk("R3 req on final tick", int'(req), 1);
      chk("R3 waiting", int'(st), 2);
      idle(1);
      chk("R10 req single", int'(req), 0);
      rsp(1'b1);
      chk("R6 exec", int'(exec_s), 1);
      chk("R6 exec state", int'(st), 3);
      idle(1);
      chk("R10 exec single", int'(exec_s), 0);
      chk("R6 back normal", int'(st), 0);
    end

    // R4: break in the run restarts it
    dwell = DW'(3);
    adv_tick(); adv_tick();
    ftick(5, 8);
    chk("R4 break to normal", int'(st), 0);
    adv_tick(); adv_tick();
    chk("R4 restarted no req", int'(req), 0);
    adv_tick();
    chk("R4 full run req", int'(req), 1);
    rsp(1'b0);

    // R5: quality swings without tick are ignored
    adv_tick();
    serv = QW'(50); nbr = QW'(0);
    idle(5);
    chk("R5 hold pending", int'(st), 1);
    adv_tick();
    chk("R5 not reset", int'(req), 0);
    adv_tick();
    chk("R5 req after run", int'(req), 1);

    // R6: response beats a coincident tick (limit 1)
    tmo = TW'(1);
    rv = 1'b1; ra = 1'b1; tick = 1'b1;
    @(negedge clk);
    rv = 1'b0; ra = 1'b0; tick = 1'b0;
    chk("R6 response priority", int'(exec_s), 1);
    idle(1);

    // R8 timeout sweep, limits 0..3
    dwell = DW'(1);
    for (int t = 0; t <= 3; t++) begin
      int eff;
      eff = (t == 0) ? 1 : t;
      tmo = TW'(t);
      adv_tick();
      chk("R8 enter wait", int'(st), 2);
      idle(20);
      chk("R8 no tick no timeout", int'(st), 2);
      for (int k = 1; k < eff; k++) begin
        adv_tick();
        chk("R8 still waiting", int'(st), 2);
      end
      adv_tick();
      chk("R8 timed out", int'(st), 0);
      chk("R8 no req on timeout", int'(req), 0);
    end

    // R9: fresh run after timeout and after reject
    dwell = DW'(3); tmo = TW'(2);
    adv_tick(); adv_tick(); adv_tick();
    chk("R9 setup req", int'(req), 1);
    adv_tick(); adv_tick();
    chk("R9 timeout", int'(st), 0);
    adv_tick();
    chk("R9 pending after timeout", int'(st), 1);
    adv_tick();
    chk("R9 no early req", int'(req), 0);
    adv_tick();
    chk("R9 req after full run", int'(req), 1);
    rsp(1'b0);
    adv_tick(); adv_tick();
    chk("R9 no req after reject", int'(req), 0);
    adv_tick();
    chk("R9 req after reject", int'(req), 1);
    rsp(1'b1);
    idle(1);

    // R10: response outside waiting has no effect
    adv_tick();
    rsp(1'b1);
    chk("R10 stray exec", int'(exec_s), 0);
    chk("R10 stray state", int'(st), 1);
    rsp(1'b0);
    chk("R10 stray reject", int'(st), 1);
    adv_tick(); adv_tick();
    chk("R10 run intact", int'(req), 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule